// File: doc/BRIEF.md
# Flash Sector Quick-Scan Sampler

This block estimates whether one 4 KB sector of a serial NOR flash is blank, wiped to zero, or holds data, without reading all 4096 bytes. Given a sector number, it issues a fixed series of short SPI read transactions at chosen offsets inside the sector. It collects 132 bytes in total and reports a two-bit class together with a one-cycle completion pulse.

The sector is treated as 16 pages of 256 bytes. Every page is probed at its start, its middle and its end. The middle probe is 4 bytes wide. The start and end probes are 2 bytes wide, except at the two outer edges of the sector, where they are widened to 4 bytes. The end probe of one page and the start probe of the next page are adjacent, so the block merges them into a single 4-byte read. As a result, every sector costs exactly 33 reads of 4 bytes each. The host starts a scan, waits for the completion pulse, and then reads the class.

Top module: `flash_sector_sampler`

## Requirements
- R1: While reset is held and after its release, `spi_cs_n` is high, `spi_sclk` is low, and `busy` and `done` are low.
- R2: Each SPI transaction sends the byte 0x03 first, then a 24-bit address, most significant bit first. The bus runs in mode 0: MOSI changes while SCLK is low, and each bit is captured on the rising SCLK edge.
- R3: One scan performs exactly 33 transactions. Each transaction lasts 64 SCLK pulses: 32 command/address bits followed by 4 data bytes. `spi_cs_n` returns high between transactions.
- R4: The transaction addresses are `sector_idx*4096` plus the offsets below, in this order:
  - offset 0;
  - then, for each page p from 0 to 14, `p*256+126` followed by `p*256+254`;
  - then `15*256+126`;
  - finally 4092.
- R5: If all 132 sampled bytes are 0xFF, `sector_class` is 0 (erased).
- R6: If all 132 sampled bytes are 0x00, `sector_class` is 2 (nullified).
- R7: Any other mix of sampled bytes gives `sector_class` 1 (programmed). This includes a single differing byte in the widened first probe, a middle probe, a merged boundary probe or the widened last probe.
- R8: Bytes of the sector outside the sampled locations have no effect on the class.
- R9: `busy` rises in the cycle after an accepted `start`. `done` pulses for one cycle as `busy` falls. `sector_class` holds its value until the next `done`.
- R10: A `start` pulse while `busy` is high is ignored. The running scan keeps its original sector.
- R11: `spi_sclk` is low whenever `spi_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan of `sector_idx` (accepted only when idle) |
| sector_idx | input | 12 | Sector number, captured at accepted start |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse when the class is updated |
| sector_class | output | 2 | 0 erased, 1 programmed, 2 nullified |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to flash |
| spi_miso | input | 1 | SPI data from flash |

## Verification
The embedded assertions check the following on every cycle:
- the idle level of SCLK whenever chip select is high;
- that the read opcode is loaded when a transaction opens;
- that the classifier's running flags never recover after a mismatch;
- that the group counter stays within the 33-entry sequence;
- that the captured sector is held for the whole scan;
- the single-cycle shape of `done`.

The following can only be shown by the bench, using a modelled flash with known contents:
- the exact order of the sampled addresses;
- the bit count of each transaction;
- that the chosen locations really decide the class, with unsampled bytes deliberately non-blank and single-byte disturbances placed at each probe type.

// File: rtl/fss_pkg.sv
package fss_pkg;

    localparam logic [7:0] READ_OPCODE = 8'h03;

    typedef enum logic [1:0] {
        CLS_ERASED     = 2'd0,
        CLS_PROGRAMMED = 2'd1,
        CLS_NULLED     = 2'd2
    } sect_class_e;

    typedef enum logic [1:0] {
        SPI_IDLE,
        SPI_LOW,
        SPI_HIGH,
        SPI_GAP
    } spi_st_e;

    typedef enum logic {
        SCAN_IDLE,
        SCAN_RUN
    } scan_st_e;

endpackage

// File: rtl/fss_offset_gen.sv
module fss_offset_gen #(
    parameter int SECT_LOG2 = 12,
    parameter int PAGE_LOG2 = 8,
    parameter int GROUPS    = 33,
    parameter int GW        = 6
) (
    input  logic [GW-1:0]        group_i,
    output logic [SECT_LOG2-1:0] offset_o
);
    localparam int PW   = SECT_LOG2 - PAGE_LOG2;
    localparam int PAGE = 1 << PAGE_LOG2;
    localparam int SECT = 1 << SECT_LOG2;
    localparam logic [PAGE_LOG2-1:0] MID_OFS  = PAGE_LOG2'(PAGE / 2 - 2);
    localparam logic [PAGE_LOG2-1:0] EDGE_OFS = PAGE_LOG2'(PAGE - 2);
    localparam logic [SECT_LOG2-1:0] LAST_OFS = SECT_LOG2'(SECT - 4);

    logic [GW-1:0] k;
    logic [PW-1:0] page;

    always_comb begin
        k    = group_i - GW'(1);
        page = PW'(k >> 1);
        if (group_i == '0) begin
            offset_o = '0;
        end else if (group_i == GW'(GROUPS - 1)) begin
            offset_o = LAST_OFS;
        end else if (!k[0]) begin
            offset_o = {page, MID_OFS};
        end else begin
            offset_o = {page, EDGE_OFS};
        end
    end

endmodule

// File: rtl/fss_spi_reader.sv
module fss_spi_reader
    import fss_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int RD_BYTES = 4,
    parameter int HALF     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              done_o,
    output logic              bvld_o,
    output logic [7:0]        bdat_o,
    output logic              sclk_o,
    output logic              cs_n_o,
    output logic              mosi_o,
    input  logic              miso_i
);
    localparam int HDR   = 8 + ADDR_W;
    localparam int TOTAL = HDR + 8 * RD_BYTES;
    localparam int BW    = $clog2(TOTAL);
    localparam int CW    = $clog2(HALF + 1);

    typedef struct packed {
        spi_st_e        st;
        logic [CW-1:0]  tmr;
        logic [BW-1:0]  bitn;
        logic [HDR-1:0] tx;
        logic [6:0]     rx;
        logic           sclk;
        logic           cs_n;
        logic           bvld;
        logic [7:0]     bdat;
        logic           done;
    } spi_t;

    spi_t q, d;
    logic tmr_end;
    logic byte_end;

    always_comb begin
        d        = q;
        d.bvld   = 1'b0;
        d.done   = 1'b0;
        tmr_end  = (q.tmr == CW'(HALF - 1));
        byte_end = (q.bitn >= BW'(HDR)) && (q.bitn[2:0] == 3'b111);
        unique case (q.st)
            SPI_IDLE: begin
                if (start_i) begin
                    d.cs_n = 1'b0;
                    d.tx   = {READ_OPCODE, addr_i};
                    d.bitn = '0;
                    d.tmr  = '0;
                    d.sclk = 1'b0;
                    d.st   = SPI_LOW;
                end
            end
            SPI_LOW: begin
                if (tmr_end) begin
                    d.tmr  = '0;
                    d.sclk = 1'b1;
                    d.st   = SPI_HIGH;
                end else begin
                    d.tmr = q.tmr + CW'(1);
                end
            end
            SPI_HIGH: begin
                if (tmr_end) begin
                    d.tmr  = '0;
                    d.sclk = 1'b0;
                    d.rx   = {q.rx[5:0], miso_i};
                    d.tx   = {q.tx[HDR-2:0], 1'b0};
                    if (byte_end) begin
                        d.bvld = 1'b1;
                        d.bdat = {q.rx, miso_i};
                    end
                    if (q.bitn == BW'(TOTAL - 1)) begin
                        d.cs_n = 1'b1;
                        d.st   = SPI_GAP;
                    end else begin
                        d.bitn = q.bitn + BW'(1);
                        d.st   = SPI_LOW;
                    end
                end else begin
                    d.tmr = q.tmr + CW'(1);
                end
            end
            SPI_GAP: begin
                if (tmr_end) begin
                    d.tmr  = '0;
                    d.done = 1'b1;
                    d.st   = SPI_IDLE;
                end else begin
                    d.tmr = q.tmr + CW'(1);
                end
            end
            default: d.st = SPI_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= SPI_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign bvld_o = q.bvld;
    assign bdat_o = q.bdat;
    assign sclk_o = q.sclk;
    assign cs_n_o = q.cs_n;
    assign mosi_o = !q.cs_n && q.tx[HDR-1];

    a_r11_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        q.cs_n |-> !q.sclk);

    a_r2_opcode_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.cs_n) |-> (q.tx[HDR-1 -: 8] == READ_OPCODE));

    a_r3_byte_after_select: assert property (@(posedge clk) disable iff (!rst_n)
        q.bvld |-> $past(!q.cs_n));

endmodule

// File: rtl/fss_classifier.sv
module fss_classifier (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       vld_i,
    input  logic [7:0] byte_i,
    output logic       all_ff_o,
    output logic       all_zero_o
);
    typedef struct packed {
        logic all_ff;
        logic all_zero;
    } cls_t;

    cls_t q, d;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.all_ff   = 1'b1;
            d.all_zero = 1'b1;
        end else if (vld_i) begin
            d.all_ff   = q.all_ff && (byte_i == 8'hFF);
            d.all_zero = q.all_zero && (byte_i == 8'h00);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign all_ff_o   = q.all_ff;
    assign all_zero_o = q.all_zero;

    a_r5_ff_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.all_ff && !clr_i) |=> !q.all_ff);

    a_r6_zero_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.all_zero && !clr_i) |=> !q.all_zero);

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !clr_i) |=> !(q.all_ff && q.all_zero));

endmodule

// File: rtl/flash_sector_sampler.sv
module flash_sector_sampler
    import fss_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int SECT_LOG2 = 12,
    parameter int PAGE_LOG2 = 8,
    parameter int HALF      = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [ADDR_W-SECT_LOG2-1:0] sector_idx,
    output logic                      busy,
    output logic                      done,
    output logic [1:0]                sector_class,
    output logic                      spi_sclk,
    output logic                      spi_cs_n,
    output logic                      spi_mosi,
    input  logic                      spi_miso
);
    localparam int SW       = ADDR_W - SECT_LOG2;
    localparam int PAGES    = 1 << (SECT_LOG2 - PAGE_LOG2);
    localparam int GROUPS   = 2 * PAGES + 1;
    localparam int GW       = $clog2(GROUPS);
    localparam int RD_BYTES = 4;

    typedef struct packed {
        scan_st_e      st;
        logic [GW-1:0] grp;
        logic [SW-1:0] sect;
        logic          go;
        logic          clr;
        logic          busy;
        logic          done;
        logic [1:0]    cls;
    } scan_t;

    scan_t q, d;

    logic [SECT_LOG2-1:0] offset;
    logic                 spi_done;
    logic                 bvld;
    logic [7:0]           bdat;
    logic                 all_ff;
    logic                 all_zero;

    fss_offset_gen #(
        .SECT_LOG2 (SECT_LOG2),
        .PAGE_LOG2 (PAGE_LOG2),
        .GROUPS    (GROUPS),
        .GW        (GW)
    ) u_ofs (
        .group_i  (q.grp),
        .offset_o (offset)
    );

    fss_spi_reader #(
        .ADDR_W   (ADDR_W),
        .RD_BYTES (RD_BYTES),
        .HALF     (HALF)
    ) u_spi (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (q.go),
        .addr_i  ({q.sect, offset}),
        .done_o  (spi_done),
        .bvld_o  (bvld),
        .bdat_o  (bdat),
        .sclk_o  (spi_sclk),
        .cs_n_o  (spi_cs_n),
        .mosi_o  (spi_mosi),
        .miso_i  (spi_miso)
    );

    fss_classifier u_cls (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (q.clr),
        .vld_i      (bvld),
        .byte_i     (bdat),
        .all_ff_o   (all_ff),
        .all_zero_o (all_zero)
    );

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.clr  = 1'b0;
        d.done = 1'b0;
        unique case (q.st)
            SCAN_IDLE: begin
                if (start) begin
                    d.sect = sector_idx;
                    d.grp  = '0;
                    d.go   = 1'b1;
                    d.clr  = 1'b1;
                    d.busy = 1'b1;
                    d.st   = SCAN_RUN;
                end
            end
            SCAN_RUN: begin
                if (spi_done) begin
                    if (q.grp == GW'(GROUPS - 1)) begin
                        d.busy = 1'b0;
                        d.done = 1'b1;
                        d.st   = SCAN_IDLE;
                        if (all_ff) begin
                            d.cls = CLS_ERASED;
                        end else if (all_zero) begin
                            d.cls = CLS_NULLED;
                        end else begin
                            d.cls = CLS_PROGRAMMED;
                        end
                    end else begin
                        d.grp = q.grp + GW'(1);
                        d.go  = 1'b1;
                    end
                end
            end
            default: d.st = SCAN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= SCAN_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy         = q.busy;
    assign done         = q.done;
    assign sector_class = q.cls;

    a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> !q.busy);

    a_r10_sector_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && $past(q.busy)) |-> $stable(q.sect));

    a_r4_group_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.grp <= GW'(GROUPS - 1));

endmodule

// File: tb/flash_sector_sampler_tb_top.sv
module flash_sector_sampler_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [11:0] sector_idx;
    logic        busy;
    logic        done;
    logic [1:0]  sector_class;
    logic        spi_sclk;
    logic        spi_cs_n;
    logic        spi_mosi;
    logic        spi_miso;

    always #10 clk = ~clk;

    flash_sector_sampler dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .sector_idx   (sector_idx),
        .busy         (busy),
        .done         (done),
        .sector_class (sector_class),
        .spi_sclk     (spi_sclk),
        .spi_cs_n     (spi_cs_n),
        .spi_mosi     (spi_mosi),
        .spi_miso     (spi_miso)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard queues
    int exp_addr[$];
    int exp_cls[$];

    // Flash model contents
    logic [7:0] bg_fill;
    int         ovr_addr = -1;
    logic [7:0] ovr_val;
    bit         armed = 1'b0;

    function automatic bit in_sample(input int off);
        int pg = off / 256;
        int po = off % 256;
        return (po < 2) || (po >= 126 && po < 130) || (po >= 254) ||
               (pg == 0 && po < 4) || (pg == 15 && po >= 252);
    endfunction

    function automatic logic [7:0] byte_at(input int a);
        if (a == ovr_addr) return ovr_val;
        if (in_sample(a % 4096)) return bg_fill;
        return 8'h5A;   // unsampled bytes never blank (R8)
    endfunction

    // Flash slave model
    int          nbits;
    int          txn_cnt;
    int          cur_addr;
    logic [31:0] shin;
    int          e_addr;
    int          ridx;
    logic [7:0]  rbyte;

    always @(negedge spi_cs_n) begin
        nbits = 0;
        txn_cnt++;
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            shin = {shin[30:0], spi_mosi};
            nbits++;
            if (nbits == 32) begin
                chk(shin[31:24] == 8'h03, "R2 read opcode", int'(shin[31:24]), 3);
                cur_addr = int'(shin[23:0]);
                if (exp_addr.size() == 0) begin
                    chk(1'b0, "R4 unexpected transaction", cur_addr, 0);
                end else begin
                    e_addr = exp_addr.pop_front();
                    chk(cur_addr == e_addr, "R4 sample address", cur_addr, e_addr);
                end
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n && nbits >= 32 && nbits < 64) begin
            ridx     = nbits - 32;
            rbyte    = byte_at(cur_addr + ridx / 8);
            spi_miso = rbyte[7 - (ridx % 8)];
        end
    end

    always @(posedge spi_cs_n) begin
        if (armed) begin
            chk(nbits == 64, "R3 clocks per transaction", nbits, 64);
            chk(spi_sclk == 1'b0, "R11 sclk low at deselect", int'(spi_sclk), 0);
        end
    end

    // Result monitor
    int e_cls;
    always @(negedge clk) begin
        if (armed && done) begin
            if (exp_cls.size() == 0) begin
                chk(1'b0, "R9 unexpected done", int'(sector_class), 0);
            end else begin
                e_cls = exp_cls.pop_front();
                chk(int'(sector_class) == e_cls, "R5/R6/R7 sector class", int'(sector_class), e_cls);
            end
            chk(busy == 1'b0, "R9 busy low at done", int'(busy), 0);
            chk(txn_cnt == 33, "R3 transactions per scan", txn_cnt, 33);
            chk(exp_addr.size() == 0, "R4 all addresses issued", exp_addr.size(), 0);
        end
    end

    task automatic run_sector(input int idx, input logic [7:0] fill, input int ovr_a,
                              input logic [7:0] ovr_v, input int cls, input bit poke);
        bg_fill  = fill;
        ovr_addr = ovr_a;
        ovr_val  = ovr_v;
        exp_addr.push_back(idx * 4096);
        for (int p = 0; p < 16; p++) begin
            exp_addr.push_back(idx * 4096 + p * 256 + 126);
            if (p < 15) exp_addr.push_back(idx * 4096 + p * 256 + 254);
            else        exp_addr.push_back(idx * 4096 + 4092);
        end
        exp_cls.push_back(cls);
        txn_cnt = 0;
        @(negedge clk);
        sector_idx = 12'(idx);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R9 busy after start", int'(busy), 1);
        if (poke) begin
            repeat (400) @(negedge clk);
            sector_idx = 12'(idx ^ 1);
            start      = 1'b1;   // R10: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        while (exp_cls.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        start      = 1'b0;
        sector_idx = '0;
        spi_miso   = 1'b0;
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1 cs_n in reset", int'(spi_cs_n), 1);
        chk(spi_sclk == 1'b0, "R1 sclk in reset", int'(spi_sclk), 0);
        chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        chk(done == 1'b0, "R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        armed = 1'b1;
        @(negedge clk);
        chk(spi_cs_n == 1'b1 && busy == 1'b0, "R1 idle after reset", int'(busy), 0);

        // R5 + R8: blank samples, unsampled byte at offset 130 forced to zero
        run_sector(0, 8'hFF, 130, 8'h00, 0, 1'b0);
        // R6: all samples zero
        run_sector(5, 8'h00, -1, 8'h00, 2, 1'b0);
        // R7: last byte of widened final probe differs
        run_sector(7, 8'hFF, 7 * 4096 + 4095, 8'h7F, 1, 1'b0);
        // R7: third byte of widened first probe differs
        run_sector(9, 8'h00, 9 * 4096 + 2, 8'h01, 1, 1'b0);
        // R4 + R5: highest sector number
        run_sector(4095, 8'hFF, -1, 8'h00, 0, 1'b0);
        // R10 + R7: restart attempt mid-scan, middle probe of page 3 differs
        run_sector(12, 8'hFF, 12 * 4096 + 3 * 256 + 128, 8'hFE, 1, 1'b1);
        // R7: second byte of page 1 in a merged boundary probe differs
        run_sector(2, 8'h00, 2 * 4096 + 257, 8'hFF, 1, 1'b0);

        // R9: result held while idle
        repeat (40) @(negedge clk);
        chk(sector_class == 2'd1, "R9 class held", int'(sector_class), 1);
        chk(busy == 1'b0 && done == 1'b0, "R9 idle after scan", int'(busy), 0);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R11 bus idle", int'(spi_sclk), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule